// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple 32-bit register bus and gives a processor read and program access to a one-time-programmable fuse array. The array is modelled as storage whose bits can only go from 0 to 1. Software first sets an access-enable bit. It then selects a command code and a row address, loads the write-data words, and sets a start bit. It polls a status register until the done flag appears and then clears the start bit. Clearing start also clears done.

Programming is protected by an unlock handshake. The unlock command must be run four times, with write-data word 0 carrying a fixed key in a fixed order. Until that handshake completes, program commands finish normally but change nothing. A lock command closes the array again. A row holds `ROW_WORDS` 32-bit words, either one or two, and a read delivers all of them at once. Command latency comes from a cycle counter, with one count for reads and unlock steps and a longer count for programming.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Register offsets and readback:
  - 0x00 holds the access-enable bit in bit 0.
  - 0x04 holds the command, keeping only the low 6 bits.
  - 0x08 holds the start bit in bit 0.
  - 0x0C is status: bit 1 is done and bit 2 is acknowledge.
  - 0x28 holds the row address.
  - 0x2C is write-data word 0 and 0x10 is read-data word 0.
  - With two-word rows, 0x64 is write-data word 1 and 0x5C is read-data word 1.
  - Every other offset reads 0, and writes to it have no effect.
  - After reset, every register and every fuse bit is 0.
- R2: A command is launched only by a write of 1 to start bit 0 when all three hold: start is currently 0, the access-enable bit is 1, and no command is in flight. Writing 1 to start while start is already 1 launches nothing. The command codes are: read 0x00, unlock 0x02, lock 0x03, program 0x0A. Any other code completes with done set and no other effect.
- R3: While the access-enable bit is 0, a start write launches nothing. Done stays 0 and the array is unchanged.
- R4: Done timing:
  - Done becomes visible exactly `SHORT_LAT` clock edges after the edge that captures the start write, for every command except program.
  - For program, the delay is `PROG_LAT` edges.
  - Launching a command clears done.
  - Writing 0 to start clears done on the next edge.
- R5: A read copies every word of the addressed row into the read-data registers on the edge where done is set.
- R6: Unlock handshake:
  - Four unlock commands must complete with write-data word 0 equal to 0xF, 0x4, 0x8 and 0xD, in that order.
  - The block becomes unlocked, and status bit 2 is set, when the fourth completes.
  - A wrong key, or any other command completing between the steps, returns the progress to step zero.
- R7: A program command that completes while the block is locked leaves the array unchanged.
- R8: A program command that completes while the block is unlocked ORs the write-data words into the addressed row. A bit that is set is never cleared.
- R9: The lock command clears the unlocked state and sets status bit 2 when it completes. Status bit 2 is cleared when the next command launches.
- R10: The address register keeps the low 16 bits of the written value. The row is selected by the low log2(`NUM_ROWS`) bits, and the address and data are captured at launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |

## Verification
A wrong unlock step count or a lost unlocked flag stays invisible until the next program command completes. It then shows up either as a row that reads back unchanged or as bits that appear when they should not, or as a status bit 2 that differs at the end of the fourth unlock step. A wrong latency counter moves the done bit in status by at least one cycle, and the per-cycle comparison of status catches that on the same cycle. A wrong row select or a missing OR shows up on the first read of the affected row, one short latency after that read starts.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned CMD_W  = 6;

  // Register byte offsets
  localparam logic [BUS_AW-1:0] REG_MODE    = 8'h00;
  localparam logic [BUS_AW-1:0] REG_CMD     = 8'h04;
  localparam logic [BUS_AW-1:0] REG_GO      = 8'h08;
  localparam logic [BUS_AW-1:0] REG_STAT    = 8'h0C;
  localparam logic [BUS_AW-1:0] REG_RD0     = 8'h10;
  localparam logic [BUS_AW-1:0] REG_ROWADDR = 8'h28;
  localparam logic [BUS_AW-1:0] REG_WD0     = 8'h2C;
  localparam logic [BUS_AW-1:0] REG_RD1     = 8'h5C;
  localparam logic [BUS_AW-1:0] REG_WD1     = 8'h64;

  // Command codes
  localparam logic [CMD_W-1:0] OP_READ   = 6'h00;
  localparam logic [CMD_W-1:0] OP_UNLOCK = 6'h02;
  localparam logic [CMD_W-1:0] OP_LOCK   = 6'h03;
  localparam logic [CMD_W-1:0] OP_PROG   = 6'h0A;

  // Status bit positions
  localparam int unsigned STAT_DONE = 1;
  localparam int unsigned STAT_ACK  = 2;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic launch;   // capture the row address and write data
    logic rowRead;  // copy the addressed row into the read-data registers
    logic rowProg;  // OR the captured data into the addressed row
  } fuseStrobe_t;

  // Key expected at each step of the unlock handshake
  function automatic logic [31:0] unlockKey(input logic [1:0] step);
    case (step)
      2'd0:    unlockKey = 32'h0000_000F;
      2'd1:    unlockKey = 32'h0000_0004;
      2'd2:    unlockKey = 32'h0000_0008;
      default: unlockKey = 32'h0000_000D;
    endcase
  endfunction

  function automatic logic [BUS_AW-1:0] wdOffset(input int unsigned lane);
    wdOffset = (lane == 0) ? REG_WD0 : REG_WD1;
  endfunction

endpackage

// File: rtl/otp_fuse_ctl.sv
module otp_fuse_ctl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned SHORT_LAT = 4,   // >= 1
  parameter int unsigned PROG_LAT  = 12   // >= 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeBit,
  input  logic             startReq,
  input  logic             startClr,
  input  logic [CMD_W-1:0] cmdReg,
  input  logic [31:0]      keyWord,
  output fuseStrobe_t      stb,
  output logic             busyFlag,
  output logic             doneFlag,
  output logic             ackFlag,
  output logic             unlockedFlag
);

  localparam int unsigned MAX_LAT = (PROG_LAT > SHORT_LAT) ? PROG_LAT : SHORT_LAT;
  localparam int unsigned CNT_W   = $clog2(MAX_LAT + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_LAT - 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic [CMD_W-1:0] opCmd;
  logic [31:0]      opKey;
  logic [1:0]       step;
  logic             launch;
  logic             finish;

  assign launch = startReq && modeBit && !busyFlag;
  assign finish = busyFlag && (cnt == '0);

  always_comb begin
    stb.launch  = launch;
    stb.rowRead = finish && (opCmd == OP_READ);
    stb.rowProg = finish && (opCmd == OP_PROG) && unlockedFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt          <= '0;
      opCmd        <= '0;
      opKey        <= '0;
      step         <= '0;
      busyFlag     <= 1'b0;
      doneFlag     <= 1'b0;
      ackFlag      <= 1'b0;
      unlockedFlag <= 1'b0;
    end else begin
      if (startClr) doneFlag <= 1'b0;
      if (launch) begin
        busyFlag <= 1'b1;
        cnt      <= (cmdReg == OP_PROG) ? PROG_LOAD : SHORT_LOAD;
        opCmd    <= cmdReg;
        opKey    <= keyWord;
        doneFlag <= 1'b0;
        ackFlag  <= 1'b0;
      end else if (finish) begin
        busyFlag <= 1'b0;
        doneFlag <= 1'b1;
        case (opCmd)
          OP_UNLOCK: begin
            if (opKey == unlockKey(step)) begin
              if (step == 2'd3) begin
                unlockedFlag <= 1'b1;
                ackFlag      <= 1'b1;
                step         <= '0;
              end else begin
                step <= step + 2'd1;
              end
            end else begin
              step <= '0;
            end
          end
          OP_LOCK: begin
            unlockedFlag <= 1'b0;
            ackFlag      <= 1'b1;
            step         <= '0;
          end
          default: step <= '0;
        endcase
      end else if (busyFlag) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/otp_fuse_dp.sv
module otp_fuse_dp
  import otp_fuse_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 2,   // 1 or 2
  parameter int unsigned NUM_ROWS  = 16   // power of two, >= 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  fuseStrobe_t       stb,
  input  logic              doneFlag,
  input  logic              ackFlag,
  output logic              modeBit,
  output logic              startReq,
  output logic              startClr,
  output logic [CMD_W-1:0]  cmdReg,
  output logic [31:0]       keyWord
);

  localparam int unsigned ROW_AW = $clog2(NUM_ROWS);
  localparam int unsigned HI     = (ROW_WORDS > 1) ? 1 : 0;

  logic                          startReg;
  logic [15:0]                   addrReg;
  logic [ROW_AW-1:0]             opRow;
  logic [ROW_WORDS-1:0][31:0]    wdWords;
  logic [ROW_WORDS-1:0][31:0]    rdWords;

  logic goWrite;
  assign goWrite  = busWe && (busAddr == REG_GO);
  assign startReq = goWrite && busWdata[0] && !startReg;
  assign startClr = goWrite && !busWdata[0];
  assign keyWord  = wdWords[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBit  <= 1'b0;
      cmdReg   <= '0;
      startReg <= 1'b0;
      addrReg  <= '0;
      opRow    <= '0;
    end else begin
      if (busWe && busAddr == REG_MODE)    modeBit <= busWdata[0];
      if (busWe && busAddr == REG_CMD)     cmdReg  <= busWdata[CMD_W-1:0];
      if (goWrite)                         startReg <= busWdata[0];
      if (busWe && busAddr == REG_ROWADDR) addrReg <= busWdata[15:0];
      if (stb.launch)                      opRow   <= addrReg[ROW_AW-1:0];
    end
  end

  // One lane per word of a row: write-data register, captured operand,
  // fuse column and read-data register.
  for (genvar w = 0; w < ROW_WORDS; w++) begin : g_lane
    logic [31:0] wdQ;
    logic [31:0] opQ;
    logic [31:0] rdQ;
    logic [31:0] col [NUM_ROWS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wdQ <= '0;
        opQ <= '0;
        rdQ <= '0;
        for (int r = 0; r < NUM_ROWS; r++) col[r] <= '0;
      end else begin
        if (busWe && busAddr == wdOffset(w)) wdQ <= busWdata;
        if (stb.launch)  opQ <= wdQ;
        if (stb.rowRead) rdQ <= col[opRow];
        if (stb.rowProg) col[opRow] <= col[opRow] | opQ;
      end
    end

    assign wdWords[w] = wdQ;
    assign rdWords[w] = rdQ;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      REG_MODE:    busRdata[0]          = modeBit;
      REG_CMD:     busRdata[CMD_W-1:0]  = cmdReg;
      REG_GO:      busRdata[0]          = startReg;
      REG_STAT: begin
        busRdata[STAT_DONE] = doneFlag;
        busRdata[STAT_ACK]  = ackFlag;
      end
      REG_ROWADDR: busRdata[15:0]       = addrReg;
      REG_WD0:     busRdata             = wdWords[0];
      REG_RD0:     busRdata             = rdWords[0];
      REG_WD1:     if (ROW_WORDS > 1) busRdata = wdWords[HI];
      REG_RD1:     if (ROW_WORDS > 1) busRdata = rdWords[HI];
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned ROW_WORDS = 2,
  parameter int unsigned NUM_ROWS  = 16,
  parameter int unsigned SHORT_LAT = 4,
  parameter int unsigned PROG_LAT  = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata
);

  fuseStrobe_t      stb;
  logic             modeBit;
  logic             startReq;
  logic             startClr;
  logic [CMD_W-1:0] cmdReg;
  logic [31:0]      keyWord;
  logic             busyFlag;
  logic             doneFlag;
  logic             ackFlag;
  logic             unlockedFlag;

  otp_fuse_ctl #(
    .SHORT_LAT(SHORT_LAT),
    .PROG_LAT (PROG_LAT)
  ) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .modeBit     (modeBit),
    .startReq    (startReq),
    .startClr    (startClr),
    .cmdReg      (cmdReg),
    .keyWord     (keyWord),
    .stb         (stb),
    .busyFlag    (busyFlag),
    .doneFlag    (doneFlag),
    .ackFlag     (ackFlag),
    .unlockedFlag(unlockedFlag)
  );

  otp_fuse_dp #(
    .ROW_WORDS(ROW_WORDS),
    .NUM_ROWS (NUM_ROWS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .busRdata(busRdata),
    .stb     (stb),
    .doneFlag(doneFlag),
    .ackFlag (ackFlag),
    .modeBit (modeBit),
    .startReq(startReq),
    .startClr(startClr),
    .cmdReg  (cmdReg),
    .keyWord (keyWord)
  );

endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
  import otp_fuse_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BUS_AW-1:0] busAddr,
  input logic              busWe,
  input logic              goBit,
  input logic              modeBit,
  input logic              busyFlag,
  input logic              doneFlag,
  input logic              ackFlag,
  input logic              unlockedFlag
);

  // R2: a command only starts while CPU access is enabled
  assert_launch_needs_mode_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> $past(modeBit));

  // R3: a start write with access disabled leaves the block idle
  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_GO && !modeBit && !busyFlag) |=> !busyFlag);

  // R4: writing 0 to start clears done on the next edge
  assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == REG_GO && !goBit && !busyFlag) |=> !doneFlag);

  // R4: done only appears as a command finishes
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> ($past(busyFlag) && !busyFlag));

  // R4: done is never shown while a command is in flight
  assert_no_done_in_flight_R4: assert property (@(posedge clk) disable iff (!rstN)
    busyFlag |-> !doneFlag);

  // R6: unlocking happens only at command completion, with acknowledge
  assert_unlock_at_finish_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unlockedFlag) |-> ($past(busyFlag) && ackFlag));

  // R9: acknowledge is cleared when a new command launches
  assert_ack_cleared_on_launch_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyFlag) |-> !ackFlag);

endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busAddr     (busAddr),
  .busWe       (busWe),
  .goBit       (busWdata[0]),
  .modeBit     (modeBit),
  .busyFlag    (busyFlag),
  .doneFlag    (doneFlag),
  .ackFlag     (ackFlag),
  .unlockedFlag(unlockedFlag)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  import otp_fuse_pkg::*;

  localparam int SHORT_LAT = 4;
  localparam int PROG_LAT  = 12;
  localparam int ROWS      = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h0C;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;   // 100 MHz

  otp_fuse_ctrl #(
    .ROW_WORDS(2), .NUM_ROWS(ROWS), .SHORT_LAT(SHORT_LAT), .PROG_LAT(PROG_LAT)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  // ---------------- behavioural reference model ----------------
  bit          mMode, mStart, mDone, mAck, mUnl;
  bit [5:0]    mCmd, mOp;
  bit [15:0]   mAddr;
  bit [31:0]   mWd [2];
  bit [31:0]   mRd [2];
  bit [31:0]   mData [2];
  bit [31:0]   mFuse [ROWS][2];
  bit [31:0]   mKey;
  int          mLeft, mRow, mStep;

  function automatic bit [31:0] keyAt(int s);
    case (s)
      0: return 32'hF;
      1: return 32'h4;
      2: return 32'h8;
      default: return 32'hD;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit busyPre;
    bit fin;
    if (!rstN) begin
      mMode = 0; mStart = 0; mDone = 0; mAck = 0; mUnl = 0;
      mCmd = 0; mOp = 0; mAddr = 0; mKey = 0; mLeft = 0; mRow = 0; mStep = 0;
      for (int w = 0; w < 2; w++) begin mWd[w] = 0; mRd[w] = 0; mData[w] = 0; end
      for (int r = 0; r < ROWS; r++) begin mFuse[r][0] = 0; mFuse[r][1] = 0; end
    end else begin
      busyPre = (mLeft > 0);
      fin = 0;
      if (busyPre) begin
        mLeft--;
        if (mLeft == 0) fin = 1;
      end
      if (fin) begin
        mDone = 1;
        if (mOp == 6'h00) begin
          mRd[0] = mFuse[mRow][0]; mRd[1] = mFuse[mRow][1];
        end else if (mOp == 6'h0A) begin
          if (mUnl) begin
            mFuse[mRow][0] |= mData[0]; mFuse[mRow][1] |= mData[1];
          end
        end else if (mOp == 6'h02) begin
          if (mKey == keyAt(mStep)) begin
            if (mStep == 3) begin mUnl = 1; mAck = 1; mStep = 0; end
            else mStep++;
          end else mStep = 0;
        end else if (mOp == 6'h03) begin
          mUnl = 0; mAck = 1;
        end
        if (mOp != 6'h02) mStep = 0;
      end
      if (busWe) begin
        case (busAddr)
          8'h00: mMode = busWdata[0];
          8'h04: mCmd = busWdata[5:0];
          8'h08: begin
            if (busWdata[0] && !mStart && mMode && !busyPre) begin
              mOp = mCmd; mKey = mWd[0]; mRow = mAddr % ROWS;
              mData[0] = mWd[0]; mData[1] = mWd[1];
              mLeft = (mCmd == 6'h0A) ? PROG_LAT : SHORT_LAT;
              mDone = 0; mAck = 0;
            end
            if (!busWdata[0] && !fin) mDone = 0;
            mStart = busWdata[0];
          end
          8'h28: mAddr = busWdata[15:0];
          8'h2C: mWd[0] = busWdata;
          8'h64: mWd[1] = busWdata;
          default: ;
        endcase
      end
    end
  end

  function automatic bit [31:0] modelRead(bit [7:0] a);
    case (a)
      8'h00: return {31'd0, mMode};
      8'h04: return {26'd0, mCmd};
      8'h08: return {31'd0, mStart};
      8'h0C: return {29'd0, mAck, mDone, 1'b0};
      8'h28: return {16'd0, mAddr};
      8'h2C: return mWd[0];
      8'h64: return mWd[1];
      8'h10: return mRd[0];
      8'h5C: return mRd[1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tagFor(bit [7:0] a);
    case (a)
      8'h0C: return "R4";
      8'h10, 8'h5C: return "R5";
      8'h28: return "R10";
      default: return "R1";
    endcase
  endfunction

  // Per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      compared++;
      if (busRdata !== modelRead(busAddr)) begin
        mismatched++;
        $display("FAIL %s: cycle %0d addr 0x%02h actual 0x%08h expected 0x%08h",
                 tagFor(busAddr), cycles, busAddr, busRdata, modelRead(busAddr));
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #2;
    busWe = 1'b0; busAddr = 8'h0C; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    busAddr = a;
    @(negedge clk);
    d = busRdata;
    @(posedge clk); #2;
    busAddr = 8'h0C;
  endtask

  // Counts negedges after the start edge until done shows: latency + 1.
  task automatic runCmd(input logic [5:0] op, input int lat, input string tag);
    int n;
    wr(8'h04, {26'd0, op});
    wr(8'h08, 32'd1);
    n = 0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (busRdata[1]) begin n = i; break; end
    end
    check(tag, n, lat + 1);
    wr(8'h08, 32'd0);
  endtask

  task automatic unlockStep(input logic [31:0] key);
    wr(8'h2C, key);
    runCmd(6'h02, SHORT_LAT, "R6");
  endtask

  task automatic progRow(input logic [31:0] w0, input logic [31:0] w1);
    wr(8'h2C, w0);
    wr(8'h64, w1);
    runCmd(6'h0A, PROG_LAT, "R4");
  endtask

  task automatic readRow(input logic [31:0] e0, input logic [31:0] e1, input string tag);
    logic [31:0] v;
    runCmd(6'h00, SHORT_LAT, "R4");
    rd(8'h10, v); check(tag, v, e0);
    rd(8'h5C, v); check(tag, v, e1);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // Reset state
    rd(8'h0C, v); check("R4", v, 32'h0);
    rd(8'h00, v); check("R1", v, 32'h0);

    // R3: access disabled, start does nothing
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1);
    repeat (8) @(posedge clk);
    rd(8'h0C, v); check("R3", v, 32'h0);
    wr(8'h08, 32'h0);

    wr(8'h00, 32'h1);
    rd(8'h00, v); check("R1", v, 32'h1);

    // R10: address masking, row 5
    wr(8'h28, 32'hABCD_2345);
    rd(8'h28, v); check("R10", v, 32'h0000_2345);
    readRow(32'h0, 32'h0, "R5");

    // R7: program while locked
    progRow(32'hA5A5_0000, 32'h77);
    readRow(32'h0, 32'h0, "R7");

    // R6: wrong key in the middle resets progress
    unlockStep(32'hF); unlockStep(32'h4); unlockStep(32'h7);
    unlockStep(32'h8); unlockStep(32'hD);
    rd(8'h0C, v); check("R6", v, 32'h0);
    progRow(32'h1, 32'h1);
    readRow(32'h0, 32'h0, "R6");

    // R6: another command between steps resets progress
    unlockStep(32'hF); unlockStep(32'h4);
    runCmd(6'h00, SHORT_LAT, "R6");
    unlockStep(32'h8); unlockStep(32'hD);
    rd(8'h0C, v); check("R6", v, 32'h0);

    // R6: correct sequence
    unlockStep(32'hF); unlockStep(32'h4); unlockStep(32'h8); unlockStep(32'hD);
    rd(8'h0C, v); check("R6", v, 32'h4);

    // R8: OR-only programming
    progRow(32'h0000_00F0, 32'h1);
    readRow(32'h0000_00F0, 32'h1, "R8");
    progRow(32'h0F00_000F, 32'h2);
    readRow(32'h0F00_00FF, 32'h3, "R8");
    progRow(32'h0, 32'h0);
    readRow(32'h0F00_00FF, 32'h3, "R8");

    // R10: row selection by low address bits
    wr(8'h28, 32'h13);
    progRow(32'h1111_1111, 32'h2222_2222);
    readRow(32'h1111_1111, 32'h2222_2222, "R10");
    wr(8'h28, 32'h5);
    readRow(32'h0F00_00FF, 32'h3, "R10");

    // R9: lock sets acknowledge, closes the array, next launch clears ack
    runCmd(6'h03, SHORT_LAT, "R9");
    rd(8'h0C, v); check("R9", v, 32'h4);
    progRow(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(8'h0C, v); check("R9", v, 32'h0);
    readRow(32'h0F00_00FF, 32'h3, "R9");

    // R2: unknown code completes with no effect
    runCmd(6'h3F, SHORT_LAT, "R2");
    rd(8'h10, v); check("R2", v, 32'h0F00_00FF);

    // R2: second start write of 1 without clearing does not relaunch
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1);
    repeat (SHORT_LAT + 2) @(posedge clk);
    wr(8'h08, 32'h1);
    rd(8'h0C, v); check("R2", v, 32'h2);
    wr(8'h08, 32'h0);
    rd(8'h0C, v); check("R4", v, 32'h0);

    // R1: field masking and unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); check("R1", v, 32'h3F);
    wr(8'h40, 32'h1234);
    rd(8'h40, v); check("R1", v, 32'h0);
    rd(8'h64, v); check("R1", v, 32'hFFFF_FFFF);

    repeat (2) @(posedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule